// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block sends bytes on a single serial line using 8N1 framing. A one-byte holding register sits in front of a frame shift register. Bit timing comes from an external baud generator as a one-cycle `baud_tick` pulse, and each bit on the line lasts from one tick to the next. Software writes a byte into the holding register. The byte moves to the shift register on the first clock edge at which the shifter is idle and transmission is enabled. The holding register can then take the next byte while the current frame is still on the line.

The block can also send the long low break character that opens a LIN-style frame header. A pulse on `brk_set` raises a sticky break request flag. The flag is sampled when the next byte is loaded into the shift register. If it is set at that moment, the byte is thrown away, and the line carries a start bit, twelve low bit periods and a stop bit. The flag clears itself at the edge that ends that stop bit. A byte queued behind the break, typically the 0x55 sync byte, then goes out as an ordinary frame.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, `tx` is 1, `hold_empty` is 1, `shift_empty` is 1 and `brk_flag` is 0. `tx` is 1 whenever `shift_empty` is 1.
- R2: A normal frame drives `tx` as follows: start bit 0, then data bits 0 to 7 (LSB first), then stop bit 1. `tx` changes only at the clock edge that takes a `baud_tick` pulse, or at the edge that loads the shift register. Each bit ends at the first tick edge after it began.
- R3: A write (`wr_en` high) into an empty holding register is taken at that clock edge. At the next edge, if `shift_empty` is 1 and `tx_en` is 1, the byte moves into the shift register. At that same edge `hold_empty` rises, `shift_empty` falls and `tx` shows the start bit.
- R4: A write while `hold_empty` is 0 is dropped. It changes neither the held byte nor any later frame.
- R5: If `brk_flag` is 1 when the shift register is loaded, the loaded byte is discarded. `tx` then carries a start bit, 12 bit periods of 0 and a stop bit of 1, which is 14 bit periods in all.
- R6: A `brk_set` pulse sets `brk_flag`. Hardware clears the flag at the tick edge that ends the stop bit of a break frame. If a set and a clear fall on the same edge, the set wins.
- R7: `brk_flag` is sampled only when the shift register is loaded. Setting it during a frame leaves that frame unchanged and turns the next loaded byte into a break.
- R8: A byte written while a break is on the line is sent as a normal frame once the break ends.
- R9: `shift_empty` stays 0 for the whole of a frame, break or normal. It returns to 1 at the edge that ends the stop bit.
- R10: While `tx_en` is 0, any frame in progress is abandoned, `tx` is 1, and both empty flags are 1. Writes made during that time are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; low aborts and flushes |
| baud_tick | input | 1 | One-cycle pulse marking the end of a bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| brk_set | input | 1 | Pulse that sets the break request flag |
| tx | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register can accept a byte |
| shift_empty | output | 1 | No frame is on the line |
| brk_flag | output | 1 | Break request flag, cleared by hardware |

## Verification
A write is captured at edge one, and the handoff to the shifter happens at edge two. So the bench expects the start bit, a raised `hold_empty` and a lowered `shift_empty` at the falling clock edge after edge two. Every bit after that is due one edge after the tick pulse that ends the previous bit. The bench drives its own tick at rising edges and samples `tx` at every falling edge in between. This confirms both the value and the duration of every bit of every frame. It sweeps all 256 byte values. The break flag's clear, the queued sync byte and the abort are each checked at the first falling edge after the rising edge that should cause them.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

  // Number of bit periods a frame occupies on the line.
  function automatic int unsigned frame_bits(input bit is_brk,
                                             input int unsigned data_w,
                                             input int unsigned zeros);
    return is_brk ? zeros + 2 : data_w + 2;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ubt_hold.sv
module ubt_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              valid,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (!tx_en) begin
      valid <= 1'b0;
    end else if (take) begin
      valid <= 1'b0;
    end else if (wr_en && !valid) begin
      valid <= 1'b1;
      data  <= wr_data;
    end
  end

endmodule

// File: rtl/ubt_brk_ctl.sv
module ubt_brk_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic done,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
    else if (done)    flag <= 1'b0;
  end

endmodule

// File: rtl/ubt_shift.sv
module ubt_shift
  import uart_brk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BRK_ZEROS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_brk,
  output logic              tx,
  output logic              busy,
  output logic              brk_active,
  output logic              brk_done,
  output logic [$clog2(max_u(DATA_W + 2, BRK_ZEROS + 2) + 1)-1:0] bits_left
);

  localparam int NORM_BITS = frame_bits(1'b0, DATA_W, BRK_ZEROS);
  localparam int BRK_BITS  = frame_bits(1'b1, DATA_W, BRK_ZEROS);
  localparam int SR_W      = max_u(NORM_BITS, BRK_BITS);
  localparam int CNT_W     = $clog2(SR_W + 1);

  logic [SR_W-1:0] shreg;
  logic [SR_W-1:0] norm_img;
  logic [SR_W-1:0] brk_img;
  logic            last_bit;

  assign norm_img = {{(SR_W - DATA_W - 1){1'b1}}, load_data, 1'b0};
  assign brk_img  = {{(SR_W - BRK_ZEROS - 1){1'b1}}, {(BRK_ZEROS + 1){1'b0}}};
  assign last_bit = busy && baud_tick && (bits_left == CNT_W'(1));
  assign brk_done = last_bit && brk_active;
  assign tx       = shreg[0];

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      shreg      <= '1;
      busy       <= 1'b0;
      brk_active <= 1'b0;
      bits_left  <= '0;
    end else if (load) begin
      shreg      <= load_brk ? brk_img : norm_img;
      busy       <= 1'b1;
      brk_active <= load_brk;
      bits_left  <= load_brk ? CNT_W'(BRK_BITS) : CNT_W'(NORM_BITS);
    end else if (busy && baud_tick) begin
      shreg     <= {1'b1, shreg[SR_W-1:1]};
      bits_left <= bits_left - CNT_W'(1);
      if (last_bit) begin
        busy       <= 1'b0;
        brk_active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BRK_ZEROS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              brk_set,
  output logic              tx,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              brk_flag
);

  localparam int CNT_W = $clog2(max_u(DATA_W + 2, BRK_ZEROS + 2) + 1);

  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  logic              brk_active;
  logic              brk_done;
  logic              load;
  logic [CNT_W-1:0]  bits_left;

  assign load        = tx_en && hold_valid && !busy;
  assign hold_empty  = !hold_valid;
  assign shift_empty = !busy;

  ubt_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .tx_en   (tx_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (load),
    .valid   (hold_valid),
    .data    (hold_data)
  );

  ubt_brk_ctl u_brk (
    .clk     (clk),
    .rst     (rst),
    .set_req (brk_set),
    .done    (brk_done),
    .flag    (brk_flag)
  );

  ubt_shift #(.DATA_W(DATA_W), .BRK_ZEROS(BRK_ZEROS)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .baud_tick  (baud_tick),
    .load       (load),
    .load_data  (hold_data),
    .load_brk   (brk_flag),
    .tx         (tx),
    .busy       (busy),
    .brk_active (brk_active),
    .brk_done   (brk_done),
    .bits_left  (bits_left)
  );

endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_en,
  input logic              baud_tick,
  input logic              wr_en,
  input logic              tx,
  input logic              hold_empty,
  input logic              shift_empty,
  input logic              brk_flag,
  input logic              brk_active,
  input logic [DATA_W-1:0] hold_data,
  input logic [CNT_W-1:0]  bits_left
);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    shift_empty |-> tx);

  // R2
  stop_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_empty && bits_left == CNT_W'(1)) |-> tx);

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!shift_empty) && !$past(baud_tick) && $past(tx_en)) |-> $stable(tx));

  // R3
  handoff_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hold_empty) && $past(tx_en)) |-> !shift_empty);

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_empty && wr_en) |=> $stable(hold_data));

  // R5
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_empty && brk_active && bits_left > CNT_W'(1)) |-> !tx);

  // R6
  brk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(brk_flag) |-> shift_empty);

  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (tx && shift_empty && hold_empty));

endmodule

bind uart_brk_tx uart_brk_tx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_en       (tx_en),
  .baud_tick   (baud_tick),
  .wr_en       (wr_en),
  .tx          (tx),
  .hold_empty  (hold_empty),
  .shift_empty (shift_empty),
  .brk_flag    (brk_flag),
  .brk_active  (brk_active),
  .hold_data   (hold_data),
  .bits_left   (bits_left)
);

// File: tb/uart_brk_tx_tb.sv
module uart_brk_tx_tb;

  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       brk_set = 1'b0;
  logic       tx, hold_empty, shift_empty, brk_flag;

  int n_chk = 0;
  int n_bad = 0;
  int div_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    div_cnt   <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
    baud_tick <= (div_cnt == DIV - 1);
  end

  uart_brk_tx u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .baud_tick(baud_tick),
    .wr_en(wr_en), .wr_data(wr_data), .brk_set(brk_set),
    .tx(tx), .hold_empty(hold_empty), .shift_empty(shift_empty),
    .brk_flag(brk_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk);
    brk_set = 1'b1;
    @(negedge clk);
    brk_set = 1'b0;
  endtask

  // Entry: at the falling edge where the start bit is first visible.
  // Exit: at the falling edge just after the tick that ends the last bit.
  task automatic check_frame(input logic [15:0] bits, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      check(tx == bits[k], req, tx, bits[k]);
      check(shift_empty == 1'b0, "R9", shift_empty, 0);
      while (!baud_tick) begin
        @(negedge clk);
        check(tx == bits[k], req, tx, bits[k]);
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] norm_bits(input logic [7:0] d);
    return {6'b111111, 1'b1, d, 1'b0};
  endfunction

  localparam logic [15:0] BRK_BITS = 16'b1110_0000_0000_0000;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(tx == 1'b1, "R1", tx, 1);
    check(hold_empty == 1'b1, "R1", hold_empty, 1);
    check(shift_empty == 1'b1, "R1", shift_empty, 1);
    check(brk_flag == 1'b0, "R1", brk_flag, 0);
    tx_en = 1'b1;

    // R2/R3: sweep every byte value
    for (int b = 0; b < 256; b++) begin
      do_write(8'(b));
      check(hold_empty == 1'b0, "R3", hold_empty, 0);
      check(shift_empty == 1'b1, "R3", shift_empty, 1);
      @(negedge clk);
      check(hold_empty == 1'b1, "R3", hold_empty, 1);
      check_frame(norm_bits(8'(b)), 10, "R2");
      check(shift_empty == 1'b1, "R9", shift_empty, 1);
      check(tx == 1'b1, "R1", tx, 1);
    end

    // R4: second write while holding register full is dropped
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h12;
    @(negedge clk);
    wr_data = 8'h34;
    @(negedge clk);
    wr_en = 1'b0;
    check(hold_empty == 1'b1, "R4", hold_empty, 1);
    check_frame(norm_bits(8'h12), 10, "R4");
    for (int i = 0; i < 40; i++) begin
      check(tx == 1'b1 && shift_empty == 1'b1, "R4", tx, 1);
      @(negedge clk);
    end

    // R5/R6/R8: break header with a queued sync byte
    pulse_brk();
    check(brk_flag == 1'b1, "R6", brk_flag, 1);
    do_write(8'hA7);
    @(negedge clk);
    check(brk_flag == 1'b1, "R6", brk_flag, 1);
    fork
      check_frame(BRK_BITS, 14, "R5");
      do_write(8'h55);
    join
    check(brk_flag == 1'b0, "R6", brk_flag, 0);
    check(shift_empty == 1'b1, "R9", shift_empty, 1);
    check(hold_empty == 1'b0, "R8", hold_empty, 0);
    @(negedge clk);
    check_frame(norm_bits(8'h55), 10, "R8");
    check(shift_empty == 1'b1 && hold_empty == 1'b1, "R8", shift_empty, 1);

    // R7: flag set mid-frame affects only the next loaded byte
    do_write(8'h3C);
    @(negedge clk);
    fork
      check_frame(norm_bits(8'h3C), 10, "R7");
      begin
        pulse_brk();
        do_write(8'h81);
      end
    join
    check(brk_flag == 1'b1, "R7", brk_flag, 1);
    @(negedge clk);
    check_frame(BRK_BITS, 14, "R7");
    check(brk_flag == 1'b0, "R6", brk_flag, 0);

    // R10: abort mid-frame and flush a queued byte
    do_write(8'hF0);
    @(negedge clk);
    do_write(8'h0F);
    check(hold_empty == 1'b0, "R10", hold_empty, 0);
    @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    check(tx == 1'b1, "R10", tx, 1);
    check(shift_empty == 1'b1, "R10", shift_empty, 1);
    check(hold_empty == 1'b1, "R10", hold_empty, 1);
    do_write(8'h66);
    check(hold_empty == 1'b1, "R10", hold_empty, 1);
    tx_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(tx == 1'b1 && shift_empty == 1'b1, "R10", tx, 1);
    end

    // R3: normal operation resumes after re-enable
    do_write(8'hC3);
    @(negedge clk);
    check_frame(norm_bits(8'hC3), 10, "R3");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule